// File: doc/BRIEF.md
# Load-Store Byte Lane Unit

This unit sits between a 32-bit register datapath and a data memory that is addressed by words. Each request carries a base register value, a signed 16-bit offset, an access size and, for stores, a source value. The unit adds the offset to the base to form the byte address. It sends the word address to memory and works out which byte lanes of the memory word the access covers.

For a store, the unit places the low bits of the source value into the selected lanes and raises one write strobe per lane. For a load, it keeps the lane position, size and extension mode of the request in a register. In the next cycle, when the memory returns the word, it picks out the addressed bytes and either sign-extends or zero-extends them to 32 bits.

An access whose address does not suit its size is flagged as misaligned and does not reach memory. A build-time parameter chooses little-endian or big-endian lane numbering.

Top module: `lsu_lane_unit`

## Requirements
- R1: The byte address is `req_base` plus `req_imm` sign-extended to 32 bits, computed modulo 2^32. In the request cycle, `mem_addr` carries bits 31:2 of that sum.
- R2: The size codes are 0 byte, 1 halfword, 2 word and 3 reserved. During a valid request, `misaligned` is high when a halfword has address bit 0 set, when a word has either of address bits 1:0 set, or when the size code is 3. A byte access never raises it.
- R3: A misaligned request has no effect on memory or on the load output: `mem_we`, `mem_re` and every bit of `mem_be` stay low, and `load_valid` stays low in the following cycle.
- R4: An accepted store raises `mem_we` and as many `mem_be` bits as the access has bytes: one for a byte, two adjacent bits for a halfword and all four for a word. `mem_be` is all zero whenever `mem_we` is low.
- R5: Store data puts the low 8 bits (byte) or the low 16 bits (halfword) of `req_wsrc` into the enabled lanes, and all lanes not enabled are zero. A word store passes `req_wsrc` through unchanged.
- R6: Lane k covers `mem_wdata`/`mem_rdata` bits 8k+7:8k. With little-endian order, byte offset o (address bits 1:0) maps to lane o. With big-endian order it maps to lane 3-o, so the byte at the lower address is the more significant byte of a halfword or word.
- R7: An accepted load raises `mem_re` in the request cycle. `load_valid` rises in the next cycle, and `load_result` in that cycle is formed from the `mem_rdata` value present in that same cycle.
- R8: A signed byte load copies bit 7 of the selected byte into result bits 31:8. A signed halfword load copies bit 15 of the selected halfword into bits 31:16.
- R9: With `req_unsigned` high, a byte load result has bits 31:8 at zero and a halfword load result has bits 31:16 at zero.
- R10: A word load returns the memory word with its bytes in address order for the selected byte order. A word store enables all four lanes.
- R11: After reset and whenever `req_valid` is low, `load_valid`, `mem_we` and `mem_re` are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word, 3 reserved) |
| req_unsigned | input | 1 | Zero-extend byte and halfword loads |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed address offset |
| req_wsrc | input | 32 | Store source register value |
| mem_addr | output | 30 | Word address to memory |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_be | output | 4 | Per-lane write strobes |
| mem_wdata | output | 32 | Lane-aligned write data |
| mem_rdata | input | 32 | Read word, one cycle after `mem_re` |
| misaligned | output | 1 | Current request is misaligned |
| load_valid | output | 1 | `load_result` holds a completed load |
| load_result | output | 32 | Extended load value |

## Verification
The only state in the unit is the lane position, size and extension mode saved from a load. If any of that is wrong, the result in the response cycle shows wrong bytes, a shifted field or wrong upper bits. The error is visible one cycle after the request, so the bench checks every load result in its response cycle. The bench runs each request on a little-endian and a big-endian copy of the unit, both driven from one byte-addressed memory model. A lane mapping or address error then appears either in the request cycle on `mem_be`, `mem_wdata` or `mem_addr`, or one access later when a stored value is read back.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } lane_size_e;

  // Number of bytes an access of the given size covers.
  function automatic int lane_bytes(lane_size_e s);
    case (s)
      SZ_BYTE: lane_bytes = 1;
      SZ_HALF: lane_bytes = 2;
      default: lane_bytes = 4;
    endcase
  endfunction

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  lane_size_e        size_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic              misal_o
);

  localparam int EXT_W = ADDR_W - IMM_W;

  logic [ADDR_W-1:0] imm_ext;

  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
  assign ea_o    = base_i + imm_ext;

  // Alignment: the address bits below the access size must be zero.
  always_comb begin
    case (size_i)
      SZ_BYTE: misal_o = 1'b0;
      SZ_HALF: misal_o = ea_o[0];
      SZ_WORD: misal_o = |ea_o[1:0];
      default: misal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer
  import lsu_lane_pkg::*;
#(
  parameter int NUM_LANES  = 4,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int OFS_W     = $clog2(NUM_LANES)
) (
  input  logic [OFS_W-1:0]     ofs_i,
  input  lane_size_e           size_i,
  output logic [OFS_W-1:0]     start_o,
  output logic [NUM_LANES-1:0] mask_o
);

  int nb;

  always_comb begin
    nb = lane_bytes(size_i);
  end

  // Lowest lane touched by the access. In big-endian order the field is
  // mirrored inside the word, so it starts below the byte offset's mirror.
  generate
    if (BIG_ENDIAN) begin : g_big
      assign start_o = OFS_W'(NUM_LANES - nb - int'(ofs_i));
    end else begin : g_little
      assign start_o = ofs_i;
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_mask
      assign mask_o[i] = (i >= int'(start_o)) && (i < (int'(start_o) + nb));
    end
  endgenerate

endmodule

// File: rtl/lsu_store_pack.sv
module lsu_store_pack
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W     = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFS_W     = $clog2(NUM_LANES)
) (
  input  logic [DATA_W-1:0]    src_i,
  input  lane_size_e           size_i,
  input  logic [OFS_W-1:0]     start_i,
  input  logic [NUM_LANES-1:0] mask_i,
  input  logic                 wr_en_i,
  output logic [DATA_W-1:0]    wdata_o,
  output logic [NUM_LANES-1:0] be_o
);

  logic [DATA_W-1:0] src_m;

  always_comb begin
    case (size_i)
      SZ_BYTE: src_m = {{(DATA_W-8){1'b0}}, src_i[7:0]};
      SZ_HALF: src_m = {{(DATA_W-16){1'b0}}, src_i[15:0]};
      default: src_m = src_i;
    endcase
  end

  assign wdata_o = src_m << {start_i, 3'b000};
  assign be_o    = wr_en_i ? mask_i : '0;

endmodule

// File: rtl/lsu_load_unpack.sv
module lsu_load_unpack
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W     = 32,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFS_W     = $clog2(NUM_LANES)
) (
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFS_W-1:0]  start_i,
  input  lane_size_e        size_i,
  input  logic              uns_i,
  output logic [DATA_W-1:0] value_o
);

  logic [DATA_W-1:0] shifted;
  logic              fill8;
  logic              fill16;

  assign shifted = rdata_i >> {start_i, 3'b000};
  assign fill8   = ~uns_i & shifted[7];
  assign fill16  = ~uns_i & shifted[15];

  always_comb begin
    case (size_i)
      SZ_BYTE: value_o = {{(DATA_W-8){fill8}}, shifted[7:0]};
      SZ_HALF: value_o = {{(DATA_W-16){fill16}}, shifted[15:0]};
      default: value_o = shifted;
    endcase
  end

endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 16,
  parameter bit BIG_ENDIAN = 1'b0,
  localparam int NUM_LANES = DATA_W / 8,
  localparam int OFS_W     = $clog2(NUM_LANES),
  localparam int WADDR_W   = ADDR_W - OFS_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic                 req_store,
  input  logic [1:0]           req_size,
  input  logic                 req_unsigned,
  input  logic [ADDR_W-1:0]    req_base,
  input  logic [IMM_W-1:0]     req_imm,
  input  logic [DATA_W-1:0]    req_wsrc,
  output logic [WADDR_W-1:0]   mem_addr,
  output logic                 mem_re,
  output logic                 mem_we,
  output logic [NUM_LANES-1:0] mem_be,
  output logic [DATA_W-1:0]    mem_wdata,
  input  logic [DATA_W-1:0]    mem_rdata,
  output logic                 misaligned,
  output logic                 load_valid,
  output logic [DATA_W-1:0]    load_result
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = rst_sync_q[1];

  // Request side.
  lane_size_e           req_size_e;
  logic [ADDR_W-1:0]    ea;
  logic                 misal_raw;
  logic [OFS_W-1:0]     req_start;
  logic [NUM_LANES-1:0] req_mask;
  logic                 acc_ok;
  logic                 wr_go;
  logic                 rd_go;

  assign req_size_e = lane_size_e'(req_size);

  lsu_ea_gen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) i_ea_gen (
    .base_i  (req_base),
    .imm_i   (req_imm),
    .size_i  (req_size_e),
    .ea_o    (ea),
    .misal_o (misal_raw)
  );

  lsu_lane_steer #(
    .NUM_LANES  (NUM_LANES),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) i_lane_steer (
    .ofs_i   (ea[OFS_W-1:0]),
    .size_i  (req_size_e),
    .start_o (req_start),
    .mask_o  (req_mask)
  );

  assign acc_ok = req_valid & ~misal_raw;
  assign wr_go  = acc_ok & req_store;
  assign rd_go  = acc_ok & ~req_store;

  lsu_store_pack #(
    .DATA_W (DATA_W)
  ) i_store_pack (
    .src_i   (req_wsrc),
    .size_i  (req_size_e),
    .start_i (req_start),
    .mask_i  (req_mask),
    .wr_en_i (wr_go),
    .wdata_o (mem_wdata),
    .be_o    (mem_be)
  );

  assign mem_addr   = ea[ADDR_W-1:OFS_W];
  assign mem_we     = wr_go;
  assign mem_re     = rd_go;
  assign misaligned = req_valid & misal_raw;

  // Response side: lane position and mode of the outstanding load.
  logic             rsp_vld_q, rsp_vld_d;
  logic [OFS_W-1:0] rsp_start_q, rsp_start_d;
  lane_size_e       rsp_size_q, rsp_size_d;
  logic             rsp_uns_q, rsp_uns_d;
  logic             rsp_cap_en;

  always_comb begin
    rsp_vld_d   = rd_go;
    rsp_cap_en  = rd_go;
    rsp_start_d = req_start;
    rsp_size_d  = req_size_e;
    rsp_uns_d   = req_unsigned;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rsp_vld_q <= 1'b0;
    end else begin
      rsp_vld_q <= rsp_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      rsp_start_q <= '0;
      rsp_size_q  <= SZ_BYTE;
      rsp_uns_q   <= 1'b0;
    end else if (rsp_cap_en) begin
      rsp_start_q <= rsp_start_d;
      rsp_size_q  <= rsp_size_d;
      rsp_uns_q   <= rsp_uns_d;
    end
  end

  logic [DATA_W-1:0] unpacked;

  lsu_load_unpack #(
    .DATA_W (DATA_W)
  ) i_load_unpack (
    .rdata_i (mem_rdata),
    .start_i (rsp_start_q),
    .size_i  (rsp_size_q),
    .uns_i   (rsp_uns_q),
    .value_o (unpacked)
  );

  assign load_valid  = rsp_vld_q;
  assign load_result = rsp_vld_q ? unpacked : '0;

endmodule

// File: rtl/lsu_lane_unit_chk.sv
module lsu_lane_unit_chk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int IMM_W      = 16,
  localparam int NUM_LANES = DATA_W / 8
) (
  input logic                 clk,
  input logic                 rst_n_sync,
  input logic                 req_valid,
  input logic                 req_store,
  input logic [1:0]           req_size,
  input logic                 req_unsigned,
  input logic [ADDR_W-1:0]    req_base,
  input logic [IMM_W-1:0]     req_imm,
  input logic                 mem_re,
  input logic                 mem_we,
  input logic [NUM_LANES-1:0] mem_be,
  input logic                 misaligned,
  input logic                 load_valid,
  input logic [DATA_W-1:0]    load_result
);

  p_byte_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_size == 2'd0) |-> !misaligned);

  p_half_odd_r2: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && req_size == 2'd1 && (req_base[0] ^ req_imm[0])) |-> misaligned);

  p_misal_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    misaligned |-> (mem_be == '0 && !mem_we && !mem_re));

  p_misal_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && misaligned) |=> !load_valid);

  p_strobe_count_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    mem_we |-> ($countones(mem_be) == ((req_size == 2'd0) ? 1 : (req_size == 2'd1) ? 2 : 4)));

  p_strobe_idle_r4: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !mem_we |-> (mem_be == '0));

  p_load_follow_r7: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (req_valid && !req_store && !misaligned) |=> load_valid);

  p_sext_byte_r8: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (load_valid && $past(req_size) == 2'd0 && !$past(req_unsigned))
      |-> (load_result[DATA_W-1:8] == {(DATA_W-8){load_result[7]}}));

  p_zext_half_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    (load_valid && $past(req_size) == 2'd1 && $past(req_unsigned))
      |-> (load_result[DATA_W-1:16] == '0));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !req_valid |=> !load_valid);

endmodule

bind lsu_lane_unit lsu_lane_unit_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .IMM_W  (IMM_W)
) i_chk (
  .clk          (clk),
  .rst_n_sync   (rst_n_sync),
  .req_valid    (req_valid),
  .req_store    (req_store),
  .req_size     (req_size),
  .req_unsigned (req_unsigned),
  .req_base     (req_base),
  .req_imm      (req_imm),
  .mem_re       (mem_re),
  .mem_we       (mem_we),
  .mem_be       (mem_be),
  .misaligned   (misaligned),
  .load_valid   (load_valid),
  .load_result  (load_result)
);

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_store, req_unsigned;
  logic [1:0]  req_size;
  logic [31:0] req_base, req_wsrc;
  logic [15:0] req_imm;

  logic [29:0] o_addr  [2];
  logic        o_re    [2];
  logic        o_we    [2];
  logic [3:0]  o_be    [2];
  logic [31:0] o_wdata [2];
  logic [31:0] rdata   [2];
  logic        o_mis   [2];
  logic        o_lv    [2];
  logic [31:0] o_res   [2];

  logic [31:0] ram     [2][16];
  logic [7:0]  ref_mem [2][64];

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  lsu_lane_unit #(.BIG_ENDIAN(1'b0)) i_lsu_lane_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_imm(req_imm), .req_wsrc(req_wsrc), .mem_addr(o_addr[0]), .mem_re(o_re[0]),
    .mem_we(o_we[0]), .mem_be(o_be[0]), .mem_wdata(o_wdata[0]), .mem_rdata(rdata[0]),
    .misaligned(o_mis[0]), .load_valid(o_lv[0]), .load_result(o_res[0]));

  lsu_lane_unit #(.BIG_ENDIAN(1'b1)) i_lsu_lane_unit_be (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_base(req_base),
    .req_imm(req_imm), .req_wsrc(req_wsrc), .mem_addr(o_addr[1]), .mem_re(o_re[1]),
    .mem_we(o_we[1]), .mem_be(o_be[1]), .mem_wdata(o_wdata[1]), .mem_rdata(rdata[1]),
    .misaligned(o_mis[1]), .load_valid(o_lv[1]), .load_result(o_res[1]));

  // Word-wide memories behind each copy, one-cycle read.
  always @(posedge clk) begin
    for (int e = 0; e < 2; e++) begin
      if (o_we[e]) begin
        for (int i = 0; i < 4; i++) begin
          if (o_be[e][i]) ram[e][o_addr[e][3:0]][i*8 +: 8] <= o_wdata[e][i*8 +: 8];
        end
      end
      if (o_re[e]) rdata[e] <= ram[e][o_addr[e][3:0]];
    end
  end

  task automatic chk(input string tag, input int e, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s order=%0d actual=%h expected=%h", tag, e, act, exp);
    end
  endtask

  // One request; called at a falling edge, returns at the next falling edge.
  task automatic acc(input bit st, input logic [1:0] sz, input bit un,
                     input logic [31:0] b, input logic [15:0] im,
                     input logic [31:0] sd, input string ltag);
    logic [31:0] ea;
    logic [31:0] exp_ld [2];
    int nb, o;
    bit mis;
    ea  = b + {{16{im[15]}}, im};
    nb  = (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    mis = (sz == 2'd3) || (sz == 2'd1 && ea[0]) || (sz == 2'd2 && ea[1:0] != 2'b00);
    o   = int'(ea[1:0]);
    req_valid = 1'b1; req_store = st; req_size = sz; req_unsigned = un;
    req_base = b; req_imm = im; req_wsrc = sd;
    #1;
    for (int e = 0; e < 2; e++) begin
      logic [3:0]  ebe;
      logic [31:0] ewd;
      logic [31:0] v;
      ebe = '0; ewd = '0; v = '0;
      for (int k = 0; k < nb; k++) begin
        int lane, sb, idx;
        lane = (e == 1) ? 3 - (o + k) : o + k;
        sb   = (e == 1) ? nb - 1 - k : k;
        if (lane >= 0 && lane < 4) begin
          ebe[lane] = 1'b1;
          ewd[lane*8 +: 8] = sd[sb*8 +: 8];
        end
        idx = int'((ea + 32'(k)) & 32'd63);
        v[sb*8 +: 8] = ref_mem[e][idx];
      end
      if (!un && nb < 4 && v[8*nb-1]) v = v | ~((32'h1 << (8*nb)) - 32'h1);
      exp_ld[e] = v;
      chk("R1", e, {2'b00, o_addr[e]}, {2'b00, ea[31:2]});
      chk("R2", e, 32'(o_mis[e]), 32'(mis));
      chk("R3", e, 32'(o_we[e]), 32'(st && !mis));
      chk("R3", e, 32'(o_re[e]), 32'(!st && !mis));
      chk((e == 1) ? "R6" : "R4", e, 32'(o_be[e]), (st && !mis) ? 32'(ebe) : 32'h0);
      if (st && !mis) chk("R5", e, o_wdata[e], ewd);
    end
    @(posedge clk);
    if (st && !mis) begin
      for (int e = 0; e < 2; e++) begin
        for (int k = 0; k < nb; k++) begin
          int sb, idx;
          sb  = (e == 1) ? nb - 1 - k : k;
          idx = int'((ea + 32'(k)) & 32'd63);
          ref_mem[e][idx] = sd[sb*8 +: 8];
        end
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    for (int e = 0; e < 2; e++) begin
      chk("R7", e, 32'(o_lv[e]), 32'(!st && !mis));
      if (!st && !mis) chk(ltag, e, o_res[e], exp_ld[e]);
    end
  endtask

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(posedge clk);
      @(negedge clk);
      for (int e = 0; e < 2; e++) begin
        chk("R11", e, 32'(o_we[e]), 32'h0);
        chk("R11", e, 32'(o_re[e]), 32'h0);
        chk("R11", e, 32'(o_lv[e]), 32'h0);
      end
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int n = 0; n < 64; n++) begin
      ref_mem[0][n] = 8'(n * 37 + 133);
      ref_mem[1][n] = 8'(n * 37 + 133);
    end
    for (int w = 0; w < 16; w++) begin
      for (int i = 0; i < 4; i++) begin
        ram[0][w][i*8 +: 8] = ref_mem[0][w*4 + i];
        ram[1][w][i*8 +: 8] = ref_mem[1][w*4 + 3 - i];
      end
    end
    rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
    req_unsigned = 1'b0; req_base = '0; req_imm = '0; req_wsrc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int e = 0; e < 2; e++) chk("R11", e, 32'(o_lv[e]), 32'h0);
    rst_n = 1'b1;
    idle(4);

    // R10 word store then word load
    acc(1, 2'd2, 0, 32'h0000_0010, 16'h0000, 32'hA1B2_C3D4, "R10");
    acc(0, 2'd2, 0, 32'h0000_0010, 16'h0000, 32'h0, "R10");
    // R8 / R9 byte loads at every offset
    for (int k = 0; k < 4; k++) begin
      acc(0, 2'd0, 0, 32'h0000_0010, 16'(k), 32'h0, "R8");
      acc(0, 2'd0, 1, 32'h0000_0010, 16'(k), 32'h0, "R9");
    end
    // halfword loads at both aligned offsets
    acc(0, 2'd1, 0, 32'h0000_0010, 16'h0000, 32'h0, "R8");
    acc(0, 2'd1, 1, 32'h0000_0010, 16'h0002, 32'h0, "R9");
    acc(0, 2'd1, 0, 32'h0000_0010, 16'h0002, 32'h0, "R8");
    // byte and halfword stores, then read the word back
    acc(1, 2'd0, 0, 32'h0000_0020, 16'h0001, 32'hFFFF_FF7E, "R5");
    acc(1, 2'd0, 0, 32'h0000_0020, 16'h0003, 32'h1234_5681, "R5");
    acc(1, 2'd1, 0, 32'h0000_0020, 16'h0002, 32'hDEAD_9C3B, "R5");
    acc(1, 2'd0, 0, 32'h0000_0020, 16'h0000, 32'h0000_00E5, "R5");
    acc(0, 2'd2, 0, 32'h0000_0020, 16'h0000, 32'h0, "R5");
    acc(0, 2'd1, 0, 32'h0000_0020, 16'h0002, 32'h0, "R8");
    // misaligned accesses and a reserved size leave memory untouched
    acc(0, 2'd1, 0, 32'h0000_0011, 16'h0000, 32'h0, "R3");
    acc(1, 2'd2, 0, 32'h0000_0030, 16'h0002, 32'h5555_AAAA, "R3");
    acc(1, 2'd1, 0, 32'h0000_0030, 16'h0003, 32'h7777_7777, "R3");
    acc(1, 2'd3, 0, 32'h0000_0030, 16'h0000, 32'h9999_9999, "R2");
    acc(0, 2'd2, 0, 32'h0000_0030, 16'h0000, 32'h0, "R3");
    acc(0, 2'd2, 0, 32'h0000_0034, 16'h0000, 32'h0, "R3");
    // R1 negative offset and address wrap
    acc(0, 2'd2, 0, 32'h0000_0100, 16'hFF10, 32'h0, "R1");
    acc(0, 2'd0, 0, 32'hFFFF_FFF0, 16'h0023, 32'h0, "R1");
    acc(1, 2'd1, 0, 32'h0000_0040, 16'hFFFE, 32'h0000_8001, "R1");
    acc(0, 2'd1, 1, 32'h0000_003C, 16'h0002, 32'h0, "R9");
    idle(2);
    finish_run();
  end

endmodule